// File: doc/BRIEF.md
# Load Data Extraction and Extension

This combinational block sits between a data memory read port and the register file write path of a processor core. It receives the full 32-bit word that memory returned, the two low address bits of the load, the access size and a signed flag. From these it produces the 32-bit value to write to the destination register.

For byte and halfword loads it picks the addressed lane out of the word. It then fills the remaining upper bits with copies of the lane's top bit or with zeros. The result is assembled as two independent 16-bit halves, and each half applies the fill on its own. The block also raises a misalignment flag whenever the address offset does not meet the rule for the access size. The core's trap logic can use that flag. While the flag is high, the data output carries no meaning.

Top module: `load_extract`

## Requirements
- R1: With size `2'b10` (word) and `addr == 2'b00`, `result` equals `mem_word` exactly and `misalign` is 0.
- R2: With size `2'b00` (byte), `result[7:0]` is byte lane `addr`, where lane n is `mem_word[8n+7:8n]`, and `misalign` is 0 for all four offsets.
- R3: For a signed byte load (`sgn == 1`), `result[31:8]` holds 24 copies of bit 7 of the selected lane.
- R4: With size `2'b01` (halfword) and `addr[0] == 0`, `result[15:0]` is `mem_word[15:0]` when `addr[1]` is 0 and `mem_word[31:16]` when `addr[1]` is 1, and `misalign` is 0.
- R5: For a signed halfword load, `result[31:16]` holds 16 copies of bit 15 of the selected half.
- R6: For unsigned byte and halfword loads (`sgn == 0`), every result bit above the loaded lane is 0.
- R7: `misalign` is 1 for a word load with `addr != 0`, for a halfword load with `addr[0] == 1`, and for the reserved size `2'b11` at any offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mem_word | input | 32 | Word returned by memory |
| addr | input | 2 | Low byte-address bits of the load |
| size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| sgn | input | 1 | 1 selects sign extension, 0 selects zero extension |
| result | output | 32 | Extended value for the register file |
| misalign | output | 1 | High when the offset breaks the size's alignment rule |

## Verification
Every result is combinational, so both `result` and `misalign` are due in the same cycle as the inputs that produce them. The driver changes the inputs on a falling clock edge and queues the expected item. The monitor pops that item and compares on the next rising edge, half a period later, when the inputs have been stable the whole time. Exactly one item is in flight at a time, so the queue order matches the stimulus order.

// File: rtl/load_ext_pkg.sv
package load_ext_pkg;
  typedef enum logic [1:0] {
    LSZ_BYTE = 2'b00,
    LSZ_HALF = 2'b01,
    LSZ_WORD = 2'b10,
    LSZ_RSVD = 2'b11
  } lsz_e;
endpackage

// File: rtl/load_lane_pick.sv
module load_lane_pick #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int OFS_W  = $clog2(LANES),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [HALF_W-1:0] half_o,
  output logic              byte_msb_o,
  output logic              half_msb_o
);
  logic [BYTE_W-1:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_i[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    byte_o = lane[ofs_i];
    half_o = ofs_i[OFS_W-1] ? word_i[DATA_W-1:HALF_W] : word_i[HALF_W-1:0];
  end

  assign byte_msb_o = byte_o[BYTE_W-1];
  assign half_msb_o = half_o[HALF_W-1];
endmodule

// File: rtl/load_half_build.sv
module load_half_build
  import load_ext_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int BYTE_W  = 8,
  parameter bit IS_HIGH = 1'b0
) (
  input  lsz_e              size_i,
  input  logic              fill_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [HALF_W-1:0] word_half_i,
  output logic [HALF_W-1:0] half_o
);
  localparam int PAD_W = HALF_W - BYTE_W;

  if (IS_HIGH) begin : g_high
    always_comb begin
      unique case (size_i)
        LSZ_WORD: half_o = word_half_i;
        default:  half_o = {HALF_W{fill_i}};
      endcase
    end
  end else begin : g_low
    always_comb begin
      unique case (size_i)
        LSZ_BYTE: half_o = {{PAD_W{fill_i}}, byte_i};
        LSZ_HALF: half_o = half_i;
        default:  half_o = word_half_i;
      endcase
    end
  end
endmodule

// File: rtl/load_align_chk.sv
module load_align_chk
  import load_ext_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  lsz_e             size_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic             misalign_o
);
  always_comb begin
    unique case (size_i)
      LSZ_BYTE: misalign_o = 1'b0;
      LSZ_HALF: misalign_o = ofs_i[0];
      LSZ_WORD: misalign_o = |ofs_i;
      default:  misalign_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/load_extract.sv
module load_extract
  import load_ext_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int HALF_W = DATA_W / 2,
  localparam int OFS_W  = $clog2(DATA_W / BYTE_W)
) (
  input  logic [DATA_W-1:0] mem_word,
  input  logic [OFS_W-1:0]  addr,
  input  logic [1:0]        size,
  input  logic              sgn,
  output logic [DATA_W-1:0] result,
  output logic              misalign
);
  lsz_e              size_e;
  logic [BYTE_W-1:0] sel_byte;
  logic [HALF_W-1:0] sel_half;
  logic              byte_msb, half_msb, fill_bit;
  logic [HALF_W-1:0] half_q [2];

  assign size_e   = lsz_e'(size);
  assign fill_bit = sgn & ((size_e == LSZ_HALF) ? half_msb : byte_msb);

  load_lane_pick #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) pick_i (
    .word_i(mem_word), .ofs_i(addr), .byte_o(sel_byte), .half_o(sel_half),
    .byte_msb_o(byte_msb), .half_msb_o(half_msb)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    load_half_build #(.HALF_W(HALF_W), .BYTE_W(BYTE_W), .IS_HIGH(h == 1)) build_i (
      .size_i(size_e), .fill_i(fill_bit), .byte_i(sel_byte), .half_i(sel_half),
      .word_half_i(mem_word[h*HALF_W +: HALF_W]), .half_o(half_q[h])
    );
  end

  assign result = {half_q[1], half_q[0]};

  load_align_chk #(.OFS_W(OFS_W)) align_i (
    .size_i(size_e), .ofs_i(addr), .misalign_o(misalign)
  );

  always_comb begin
    // R1
    word_pass_chk: assert (!(size_e == LSZ_WORD && addr == '0) || (result == mem_word && !misalign));
    // R6
    unsigned_byte_zero_chk: assert (!(size_e == LSZ_BYTE && !sgn) || result[DATA_W-1:BYTE_W] == '0);
    // R3
    signed_byte_fill_chk: assert (!(size_e == LSZ_BYTE && sgn) ||
                                  result[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){result[BYTE_W-1]}});
    // R5
    signed_half_fill_chk: assert (!(size_e == LSZ_HALF && sgn && !addr[0]) ||
                                  result[DATA_W-1:HALF_W] == {HALF_W{result[HALF_W-1]}});
    // R7
    half_odd_chk: assert (!(size_e == LSZ_HALF && addr[0]) || misalign);
    // R2
    byte_never_misalign_chk: assert (!(size_e == LSZ_BYTE) || !misalign);
  end
endmodule

// File: tb/load_extract_tb.sv
module load_extract_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_word = '0;
  logic [1:0]  addr = '0;
  logic [1:0]  size = '0;
  logic        sgn = 1'b0;
  logic [31:0] result;
  logic        misalign;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        mis;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  load_extract dut_i (.mem_word(mem_word), .addr(addr), .size(size), .sgn(sgn),
                      .result(result), .misalign(misalign));

  function automatic exp_t model(logic [31:0] w, logic [1:0] a, logic [1:0] s, logic sg);
    exp_t e;
    logic [31:0] sh;
    sh = w >> (8 * a);
    e.res = '0;
    case (s)
      2'b00: begin
        e.mis = 1'b0;
        e.res = sg ? 32'($signed(sh[7:0])) : {24'd0, sh[7:0]};
        e.tag = sg ? "R2,R3" : "R2,R6";
      end
      2'b01: begin
        e.mis = a[0];
        e.res = sg ? 32'($signed(sh[15:0])) : {16'd0, sh[15:0]};
        e.tag = e.mis ? "R7" : (sg ? "R4,R5" : "R4,R6");
      end
      2'b10: begin
        e.mis = (a != 2'b00);
        e.res = w;
        e.tag = e.mis ? "R7" : "R1";
      end
      default: begin
        e.mis = 1'b1;
        e.tag = "R7";
      end
    endcase
    return e;
  endfunction

  task automatic drive(logic [31:0] w, logic [1:0] a, logic [1:0] s, logic sg);
    @(negedge clk);
    mem_word = w; addr = a; size = s; sgn = sg;
    sb.push_back(model(w, a, s, sg));
  endtask

  always @(posedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (misalign !== e.mis || (!e.mis && result !== e.res)) begin
        fails++;
        $display("FAIL %s: size=%b addr=%b sgn=%b got res=%h mis=%b exp res=%h mis=%b",
                 e.tag, size, addr, sgn, result, misalign, e.res, e.mis);
      end
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h8070_F00F;
    pats[1] = 32'h7F80_01FF;
    pats[2] = 32'hDEAD_BEEF;
    pats[3] = 32'h1234_5678;
    // Idle inputs during reset: unsigned byte of zero word (R2)
    drive(32'h0, 2'b00, 2'b00, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++)
        for (int sg = 0; sg < 2; sg++)
          for (int a = 0; a < 4; a++)
            drive(pats[p], 2'(a), 2'(s), 1'(sg));
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, got cycles=%0d exp <5000", cyc);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule